// File: doc/BRIEF.md
# Timer Capture/Compare Channel Pair

This block serves two general registers that share one free-running up-counter. The counter is outside the block; its value comes in on `cnt_i`. Each register has a 4-bit I/O control field. The field makes the register either an output-compare register or an input-capture register, and it sets the pin behaviour for that mode.

In compare mode the register drives its own output pin. Writing an enabled code puts the pin at an initial level. After that, each match of the counter against the register clears, sets or toggles the pin. In capture mode the register takes a copy of the counter. The trigger is either chosen edges of a synchronised input pin, or count events from a neighbouring cascaded counter. Both modes share one sticky flag per register, set on a match or on a capture. A per-register buffer-mode input turns the register's function off completely.

Software reaches the block through a plain register port, one word per address (8 bits at the default width). The control byte is at address 0, the flags at address 1, and the two general registers at addresses 2 and 3.

Top module: `tmr_ccp_pair`

## Requirements
- R1: After reset the control byte, both flags and both general registers read 0, and both output enables and both pins are low.
- R2: The control byte at address 0 reads back what was written. Bits 3:0 are the field of register 0 and bits 7:4 are the field of register 1. Within a field, bit 3 = 0 selects compare mode and bit 3 = 1 selects capture mode.
- R3: In compare mode, low three bits 000 or 100 disable the output: the output enable is low and the pin is held low.
- R4: Writing a compare code with enabled output makes the output enable high and the pin equal to field bit 2, visible in the cycle after the write.
- R5: In compare mode, a match (counter equal to register) drives the pin according to field bits 1:0: 01 drives it to 0, 10 drives it to 1, 11 toggles it. The new level is visible in the cycle after the match.
- R6: A compare match sets the register's flag, whether or not the output is enabled. The flag stays set until a write to address 1 puts 0 in bit i (register i). Writing 1 leaves the flag unchanged.
- R7: In capture mode with field bit 2 = 0, the source is the register's input pin, passed through a two-flop synchronizer. Bits 1:0 = 00 capture on a rising edge, 01 on a falling edge, and 1x on both edges. A pin change set up before clock edge k loads the counter value into the register at edge k+2 and sets the flag.
- R8: In capture mode with field bit 2 = 1, every cycle in which `cas_tick_i` is high loads the counter into the register at that clock edge and sets the flag. Field bits 1:0 are ignored.
- R9: While `cas_psc_i` is 000, `cas_tick_i` produces no capture.
- R10: While `buf_en_i[i]` is high, register i has no compare output (the enable and the pin are low), no capture and no flag set. The register can still be written and read over the register port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_i | input | CNT_W | Free-running counter value |
| cas_tick_i | input | 1 | Count event (up or down) of the neighbouring cascaded counter |
| cas_psc_i | input | 3 | Prescaler select of the neighbouring counter |
| buf_en_i | input | 2 | Buffer-mode veto, one bit per register |
| cap_pin_i | input | 2 | Capture input pins, asynchronous |
| we_i | input | 1 | Register port write strobe |
| addr_i | input | 2 | Register port address: 0 control, 1 flags, 2 register 0, 3 register 1 |
| wdata_i | input | CNT_W | Register port write data |
| rdata_o | output | CNT_W | Register port read data, combinational from the address |
| flag_o | output | 2 | Sticky match/capture flags |
| cmp_pin_o | output | 2 | Compare output pins |
| cmp_oe_o | output | 2 | Compare output enables |

## Verification
If the stored control field is decoded wrongly, the fault shows on the enable or pin the cycle after the control write, or on the pin the cycle after the first match. If the synchronizer depth or the edge selection is wrong, the register value changes one edge early, one edge late, or on the wrong pin direction, and a read-back shows it. A missing buffer or prescaler veto shows as a flag that rises, or a register value that moves, on the cycle of the vetoed event. Every fault therefore appears within three clock edges of its cause.

// File: rtl/tmr_ccp_pkg.sv
package tmr_ccp_pkg;
  typedef struct packed {
    logic       cap;  // 1: capture register
    logic       sel;  // compare: initial level, capture: cascade source
    logic [1:0] low;
  } io_field_t;

  function automatic logic cmp_out_en(io_field_t f);
    return !f.cap && (f.low != 2'b00);
  endfunction
endpackage

// File: rtl/tmr_ccp_edge.sv
module tmr_ccp_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o,
  output logic fall_o
);
  localparam int LEN = STAGES + 1;
  logic [LEN-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[LEN-2:0], d_i};
  end

  assign rise_o = sh_q[LEN-2] & ~sh_q[LEN-1];
  assign fall_o = ~sh_q[LEN-2] & sh_q[LEN-1];
endmodule

// File: rtl/tmr_ccp_chan.sv
module tmr_ccp_chan
  import tmr_ccp_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  io_field_t        field_i,
  input  logic             ctrl_we_i,
  input  io_field_t        field_d_i,
  input  logic             buf_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             pin_i,
  input  logic             cas_evt_i,
  input  logic             gr_we_i,
  input  logic [CNT_W-1:0] gr_wdata_i,
  input  logic             flag_clr_i,
  output logic [CNT_W-1:0] gr_o,
  output logic             flag_o,
  output logic             cmp_pin_o,
  output logic             cmp_oe_o
);
  logic [CNT_W-1:0] gr_q;
  logic flag_q, pin_q;
  logic rise, fall, pin_evt, cap_evt, match, oe;

  tmr_ccp_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .rise_o(rise),
    .fall_o(fall)
  );

  always_comb begin
    unique case (field_i.low)
      2'b00:   pin_evt = rise;
      2'b01:   pin_evt = fall;
      default: pin_evt = rise | fall;
    endcase
  end

  assign cap_evt = !buf_i && field_i.cap && (field_i.sel ? cas_evt_i : pin_evt);
  assign match   = !buf_i && !field_i.cap && (cnt_i == gr_q);
  assign oe      = !buf_i && cmp_out_en(field_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      gr_q <= '0;
    else if (cap_evt) gr_q <= cnt_i;
    else if (gr_we_i) gr_q <= gr_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                flag_q <= 1'b0;
    else if (match || cap_evt)  flag_q <= 1'b1;
    else if (flag_clr_i)        flag_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q <= 1'b0;
    end else if (ctrl_we_i && !buf_i && cmp_out_en(field_d_i)) begin
      pin_q <= field_d_i.sel;
    end else if (match && oe) begin
      unique case (field_i.low)
        2'b01:   pin_q <= 1'b0;
        2'b10:   pin_q <= 1'b1;
        default: pin_q <= ~pin_q;
      endcase
    end else if (!oe) begin
      pin_q <= 1'b0;
    end
  end

  assign gr_o      = gr_q;
  assign flag_o    = flag_q;
  assign cmp_oe_o  = oe;
  assign cmp_pin_o = oe & pin_q;
endmodule

// File: rtl/tmr_ccp_pair.sv
module tmr_ccp_pair
  import tmr_ccp_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             cas_tick_i,
  input  logic [2:0]       cas_psc_i,
  input  logic [1:0]       buf_en_i,
  input  logic [1:0]       cap_pin_i,
  input  logic             we_i,
  input  logic [1:0]       addr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rdata_o,
  output logic [1:0]       flag_o,
  output logic [1:0]       cmp_pin_o,
  output logic [1:0]       cmp_oe_o
);
  localparam int N_REG  = 2;
  localparam int FLD_W  = 4;
  localparam int CTRL_W = N_REG * FLD_W;

  logic [CTRL_W-1:0] ctrl_q;
  logic              ctrl_we, cas_evt;
  logic [CNT_W-1:0]  gr [N_REG];

  assign ctrl_we = we_i && (addr_i == 2'd0);
  // an undivided neighbour clock gives no usable cascade events
  assign cas_evt = cas_tick_i && (cas_psc_i != 3'b000);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= wdata_i[CTRL_W-1:0];
  end

  for (genvar i = 0; i < N_REG; i++) begin : g_ch
    tmr_ccp_chan #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_ch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .field_i   (io_field_t'(ctrl_q[i*FLD_W +: FLD_W])),
      .ctrl_we_i (ctrl_we),
      .field_d_i (io_field_t'(wdata_i[i*FLD_W +: FLD_W])),
      .buf_i     (buf_en_i[i]),
      .cnt_i     (cnt_i),
      .pin_i     (cap_pin_i[i]),
      .cas_evt_i (cas_evt),
      .gr_we_i   (we_i && (addr_i == 2'(2 + i))),
      .gr_wdata_i(wdata_i),
      .flag_clr_i(we_i && (addr_i == 2'd1) && !wdata_i[i]),
      .gr_o      (gr[i]),
      .flag_o    (flag_o[i]),
      .cmp_pin_o (cmp_pin_o[i]),
      .cmp_oe_o  (cmp_oe_o[i])
    );
  end

  always_comb begin
    unique case (addr_i)
      2'd0:    rdata_o = CNT_W'(ctrl_q);
      2'd1:    rdata_o = CNT_W'(flag_o);
      2'd2:    rdata_o = gr[0];
      default: rdata_o = gr[1];
    endcase
  end
endmodule

// File: rtl/tmr_ccp_pair_chk.sv
module tmr_ccp_pair_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             we_i,
  input logic [1:0]       addr_i,
  input logic [CNT_W-1:0] wdata_i,
  input logic [1:0]       buf_en_i,
  input logic [1:0]       flag_o,
  input logic [1:0]       cmp_pin_o,
  input logic [1:0]       cmp_oe_o
);
  for (genvar i = 0; i < 2; i++) begin : g_a
    a_r3_pin_low_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cmp_oe_o[i] |-> !cmp_pin_o[i]);

    a_r4_init_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && addr_i == 2'd0 && !wdata_i[4*i+3] && wdata_i[4*i+:2] != 2'b00 && !buf_en_i[i])
      |=> (buf_en_i[i] || (cmp_oe_o[i] && cmp_pin_o[i] == $past(wdata_i[4*i+2]))));

    a_r6_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_o[i] && !(we_i && addr_i == 2'd1 && !wdata_i[i])) |=> flag_o[i]);

    a_r10_buf_no_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
      buf_en_i[i] |-> !cmp_oe_o[i]);

    a_r10_buf_no_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flag_o[i]) |-> !$past(buf_en_i[i]));
  end
endmodule

bind tmr_ccp_pair tmr_ccp_pair_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/tmr_ccp_pair_tb.sv
`timescale 1ns/1ps
module tmr_ccp_pair_tb_top;
  localparam int W = 8;
  localparam real CYC = 4.0;

  logic clk = 0, rst_ni = 0;
  logic [W-1:0] cnt = 8'hFF;
  logic cas_tick = 0;
  logic [2:0] cas_psc = 3'b001;
  logic [1:0] buf_en = 0, cap_pin = 0;
  logic we = 0;
  logic [1:0] addr = 0;
  logic [W-1:0] wdata = 0, rdata;
  logic [1:0] flag, cpin, coe;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CYC/2) clk = ~clk;

  tmr_ccp_pair #(.CNT_W(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .cnt_i(cnt), .cas_tick_i(cas_tick),
    .cas_psc_i(cas_psc), .buf_en_i(buf_en), .cap_pin_i(cap_pin),
    .we_i(we), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .flag_o(flag), .cmp_pin_o(cpin), .cmp_oe_o(coe));

  // compare code (bits 2:0), expected enable, initial pin, pin after one match
  localparam logic [5:0] VEC [8] = '{
    6'b000_0_0_0, 6'b001_1_0_0, 6'b010_1_0_1, 6'b011_1_0_1,
    6'b100_0_0_0, 6'b101_1_1_0, 6'b110_1_1_1, 6'b111_1_1_0};

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [1:0] a, logic [W-1:0] d);
    addr = a; wdata = d; we = 1;
    tick();
    we = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [W-1:0] d);
    addr = a; #0.5; d = rdata;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CYC * 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [W-1:0] d;
    #(CYC * 3); rst_ni = 1;
    tick();

    // R1 reset state
    rd(2'd0, d); chk("R1 ctrl", d, 0);
    rd(2'd1, d); chk("R1 flags", d, 0);
    rd(2'd2, d); chk("R1 gr0", d, 0);
    rd(2'd3, d); chk("R1 gr1", d, 0);
    chk("R1 oe", coe, 0);
    chk("R1 pin", cpin, 0);

    wr(2'd2, 8'h40);

    // compare code table on register 0
    for (int k = 0; k < 8; k++) begin
      logic [2:0] code;
      code = VEC[k][5:3];
      wr(2'd1, 8'h00);
      wr(2'd0, {5'b0, code});
      rd(2'd0, d); chk("R2 readback", d, {5'b0, code});
      chk("R3 R4 oe", coe[0], VEC[k][2]);
      chk("R3 R4 init pin", cpin[0], VEC[k][1]);
      cnt = 8'h40; tick(); cnt = 8'hFF;
      chk("R5 pin after match", cpin[0], VEC[k][0]);
      chk("R6 flag on match", flag[0], 1'b1);
      tick();
      chk("R6 flag held", flag[0], 1'b1);
    end

    // R2 upper field drives register 1
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h30);
    chk("R2 reg1 oe", coe, 2'b10);
    chk("R2 reg1 init", cpin[1], 1'b0);
    wr(2'd3, 8'h22);
    cnt = 8'h22; tick(); cnt = 8'hFF;
    chk("R5 reg1 toggle", cpin[1], 1'b1);
    chk("R6 reg1 flag", flag, 2'b10);
    cnt = 8'h22; tick(); cnt = 8'hFF;
    chk("R5 reg1 toggle back", cpin[1], 1'b0);
    wr(2'd1, 8'h02);
    chk("R6 write1 keeps", flag, 2'b10);
    wr(2'd1, 8'h00);
    chk("R6 clear", flag, 2'b00);

    // R7 pin capture, rising
    wr(2'd0, 8'h08);
    cnt = 8'h11; cap_pin[0] = 1;
    tick(2);
    rd(2'd2, d); chk("R7 not before k+2", d, 8'h40);
    tick();
    rd(2'd2, d); chk("R7 rising capture", d, 8'h11);
    chk("R7 flag", flag[0], 1'b1);
    wr(2'd1, 8'h00);
    cnt = 8'h33; cap_pin[0] = 0; tick(4);
    rd(2'd2, d); chk("R7 rising ignores fall", d, 8'h11);
    chk("R7 no flag", flag[0], 1'b0);
    // falling
    wr(2'd0, 8'h09);
    cnt = 8'h44; cap_pin[0] = 1; tick(4);
    rd(2'd2, d); chk("R7 falling ignores rise", d, 8'h11);
    cnt = 8'h55; cap_pin[0] = 0; tick(4);
    rd(2'd2, d); chk("R7 falling capture", d, 8'h55);
    // both
    wr(2'd0, 8'h0A);
    cnt = 8'h66; cap_pin[0] = 1; tick(4);
    rd(2'd2, d); chk("R7 both rise", d, 8'h66);
    cnt = 8'h77; cap_pin[0] = 0; tick(4);
    rd(2'd2, d); chk("R7 both fall", d, 8'h77);

    // R8 cascade source, low bits ignored
    wr(2'd0, 8'h0F);
    wr(2'd1, 8'h00);
    cnt = 8'h12; cas_tick = 1; tick(); cas_tick = 0;
    rd(2'd2, d); chk("R8 cascade capture", d, 8'h12);
    chk("R8 flag", flag[0], 1'b1);
    wr(2'd0, 8'h0C);
    cnt = 8'h13; cas_tick = 1; tick(); cas_tick = 0;
    rd(2'd2, d); chk("R8 low bits 00", d, 8'h13);
    // R9 undivided neighbour clock
    wr(2'd1, 8'h00);
    cas_psc = 3'b000; cnt = 8'h34; cas_tick = 1; tick(); cas_tick = 0;
    rd(2'd2, d); chk("R9 no capture", d, 8'h13);
    chk("R9 no flag", flag[0], 1'b0);
    cas_psc = 3'b001;

    // R10 buffer veto
    buf_en[0] = 1;
    wr(2'd0, 8'h03);
    chk("R10 oe off", coe[0], 1'b0);
    chk("R10 pin low", cpin[0], 1'b0);
    wr(2'd2, 8'h40);
    rd(2'd2, d); chk("R10 bus write", d, 8'h40);
    cnt = 8'h40; tick(); cnt = 8'hFF;
    chk("R10 no match flag", flag[0], 1'b0);
    chk("R10 no pin", cpin[0], 1'b0);
    wr(2'd0, 8'h0C);
    cnt = 8'h5A; cas_tick = 1; tick(); cas_tick = 0;
    rd(2'd2, d); chk("R10 no capture", d, 8'h40);
    chk("R10 no capture flag", flag[0], 1'b0);
    buf_en[0] = 0;
    cnt = 8'h5B; cas_tick = 1; tick(); cas_tick = 0;
    rd(2'd2, d); chk("R10 released", d, 8'h5B);

    done = 1;
    finish_run();
  end
endmodule